// File: doc/BRIEF.md
# Phase-Multiplexed Two-Read One-Write Register File

This block is a register file for a pipelined core that must fetch two source operands and retire one result in every register-file cycle, while keeping only one storage array. Each register-file cycle takes two edges of the block clock. An internal toggle divides it into a read half and a write half. At the edge that closes the read half, both read ports sample their addresses and capture the addressed words into output registers. At the edge that closes the write half, the write port commits its word. The output `phase_o` tells the surrounding pipeline which half is current. Inputs for a cycle are held across both halves.

Every cell holds its bit twice: once in a true plane and once in a complement plane. The write driver loads both planes from a complementary line pair. Each read port senses only one plane: port A reads the complement plane and inverts it, and port B reads the true plane. Register 0 is hard-wired to zero. Because reads close before the write commits, a read in the same cycle as a write to the same register returns the previous contents.

Top module: `rf_phase_dual_read`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, sets `phase_o` to 0 (read half) and clears both read data outputs.
- R2: `phase_o` alternates on every clock edge after reset. The value 0 marks the read half and 1 marks the write half.
- R3: At the edge that ends the read half, port A captures the register named by `rd_a_addr`. `rd_a_data` then holds that value until the next read-half-ending edge.
- R4: Port B works independently of port A, in the same way. When both ports name the same register in a cycle, they return identical words.
- R5: At the edge that ends the write half, if `wr_en` is 1, the full `wr_data` word is stored in the register named by `wr_addr`. Reads return it from the next register-file cycle onward.
- R6: A read in the same cycle as a write to the same register returns the contents from before that write.
- R7: When `wr_en` is 0 at the edge that ends the write half, no register changes.
- R8: Register 0 always reads as zero, and writes addressed to it are dropped.
- R9: `wr_en`, `wr_addr` and `wr_data` are ignored at the edge that ends the read half.
- R10: Read addresses are ignored at the edge that ends the write half. Read data captured in the read half is not disturbed by address changes during the write half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; two edges form one register-file cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase_o | output | 1 | 0 = read half, 1 = write half |
| rd_a_addr | input | AW | Register index for read port A |
| rd_b_addr | input | AW | Register index for read port B |
| wr_en | input | 1 | Write request for the current cycle |
| wr_addr | input | AW | Register index for the write port |
| wr_data | input | WIDTH | Word to be written |
| rd_a_data | output | WIDTH | Word captured by read port A |
| rd_b_data | output | WIDTH | Word captured by read port B |

## Verification
The hardest situation to reach from the ports is one where the ordering inside a cycle matters. This includes a read and a write to the same register in the same cycle, and input changes that fall in only one of the two halves. The stimulus vector table places several same-register read/write pairs back to back, so that each expected value exposes whether the write landed before or after the read. Directed sequences then raise the write request only during the read half, and change the read addresses only during the write half. Both of these must leave the captured and stored values untouched.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

    parameter int unsigned RF_DEPTH = 32;
    parameter int unsigned RF_WIDTH = 32;

    // Half of a register-file cycle
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } rf_phase_e;

    function automatic rf_phase_e rf_phase_next(rf_phase_e cur);
        return (cur == PH_READ) ? PH_WRITE : PH_READ;
    endfunction

    // Row 0 is the constant-zero register and never gets a write line
    function automatic logic rf_row_writable(int unsigned idx);
        return idx != 0;
    endfunction

endpackage

// File: rtl/rf_phase_ctrl.sv
`timescale 1ns/1ps
module rf_phase_ctrl
    import rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output rf_phase_e phase_o,
    output logic      rd_capture_o,
    output logic      wr_commit_o
);

    rf_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_READ;
        end else begin
            phase_q <= rf_phase_next(phase_q);
        end
    end

    assign phase_o      = phase_q;
    assign rd_capture_o = (phase_q == PH_READ);
    assign wr_commit_o  = (phase_q == PH_WRITE);

    // R2: a read half is always followed by a write half and back
    p_read_then_write_r2: assert property (@(posedge clk) disable iff (rst)
        rd_capture_o |=> wr_commit_o);
    p_write_then_read_r2: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |=> rd_capture_o);

endmodule

// File: rtl/rf_row_decoder.sv
`timescale 1ns/1ps
module rf_row_decoder
    import rf_pkg::*;
#(
    parameter  int unsigned DEPTH = RF_DEPTH,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [AW-1:0]    addr_i,
    output logic [DEPTH-1:0] wl_o
);

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        if (rf_row_writable(r)) begin : g_live
            assign wl_o[r] = en_i && (addr_i == AW'(r));
        end else begin : g_tied
            assign wl_o[r] = 1'b0;
        end
    end

    // R5: at most one row is written per cycle
    p_wl_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wl_o));

endmodule

// File: rtl/rf_write_driver.sv
`timescale 1ns/1ps
module rf_write_driver #(
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] bl_o,
    output logic [WIDTH-1:0] blb_o
);

    // Idle: both lines held high (precharged); active: complementary pair
    always_comb begin
        if (en_i) begin
            bl_o  = data_i;
            blb_o = ~data_i;
        end else begin
            bl_o  = '1;
            blb_o = '1;
        end
    end

endmodule

// File: rtl/rf_cell_array.sv
`timescale 1ns/1ps
module rf_cell_array #(
    parameter  int unsigned DEPTH = rf_pkg::RF_DEPTH,
    parameter  int unsigned WIDTH = rf_pkg::RF_WIDTH,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] wl_i,
    input  logic [WIDTH-1:0] bl_i,
    input  logic [WIDTH-1:0] blb_i,
    input  logic             rd_capture_i,
    input  logic [AW-1:0]    ra_a_i,
    input  logic [AW-1:0]    ra_b_i,
    output logic [WIDTH-1:0] rd_a_o,
    output logic [WIDTH-1:0] rd_b_o
);

    logic [DEPTH-1:0][WIDTH-1:0] plane_t;
    logic [DEPTH-1:0][WIDTH-1:0] plane_c;
    logic [WIDTH-1:0]            sense_a;
    logic [WIDTH-1:0]            sense_b;
    logic [WIDTH-1:0]            rd_a_q;
    logic [WIDTH-1:0]            rd_b_q;

    // Storage: true and complement planes loaded from the line pair
    always_ff @(posedge clk) begin
        if (rst) begin
            plane_t <= '0;
            plane_c <= '1;
        end else begin
            for (int r = 1; r < DEPTH; r++) begin
                if (wl_i[r]) begin
                    plane_t[r] <= bl_i;
                    plane_c[r] <= blb_i;
                end
            end
        end
    end

    // Single-ended sensing: A from the complement plane, B from the true plane
    always_comb begin
        sense_a = (ra_a_i == '0) ? '0 : ~plane_c[ra_a_i];
        sense_b = (ra_b_i == '0) ? '0 : plane_t[ra_b_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_a_q <= '0;
            rd_b_q <= '0;
        end else if (rd_capture_i) begin
            rd_a_q <= sense_a;
            rd_b_q <= sense_b;
        end
    end

    assign rd_a_o = rd_a_q;
    assign rd_b_o = rd_b_q;

    // R4: both ports agree when they name the same register
    p_same_row_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_capture_i && ra_a_i == ra_b_i) |=> (rd_a_q == rd_b_q));

    // R5: every stored word keeps its two planes complementary
    p_planes_agree_r5: assert property (@(posedge clk) disable iff (rst)
        rd_capture_i |-> (plane_t[ra_b_i] == ~plane_c[ra_b_i]));

    // R7: with no write line raised the storage holds
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(|wl_i) |=> ($stable(plane_t) && $stable(plane_c)));

    // R8: register 0 reads as zero on port A
    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_capture_i && ra_a_i == '0) |=> (rd_a_q == '0));

endmodule

// File: rtl/rf_phase_dual_read.sv
`timescale 1ns/1ps
module rf_phase_dual_read
    import rf_pkg::*;
#(
    parameter  int unsigned DEPTH = RF_DEPTH,
    parameter  int unsigned WIDTH = RF_WIDTH,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             phase_o,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic [AW-1:0]    rd_b_addr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_a_data,
    output logic [WIDTH-1:0] rd_b_data
);

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } wr_bundle_t;

    rf_phase_e        phase;
    logic             rd_capture;
    logic             wr_commit;
    wr_bundle_t       wr_req;
    logic [DEPTH-1:0] wl;
    logic [WIDTH-1:0] bl;
    logic [WIDTH-1:0] blb;

    rf_phase_ctrl u_phase (
        .clk          (clk),
        .rst          (rst),
        .phase_o      (phase),
        .rd_capture_o (rd_capture),
        .wr_commit_o  (wr_commit)
    );

    // Write request only takes effect in the write half
    always_comb begin
        wr_req.en   = wr_en && wr_commit;
        wr_req.addr = wr_addr;
        wr_req.data = wr_data;
    end

    rf_row_decoder #(.DEPTH(DEPTH)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .en_i   (wr_req.en),
        .addr_i (wr_req.addr),
        .wl_o   (wl)
    );

    rf_write_driver #(.WIDTH(WIDTH)) u_wdrv (
        .en_i   (wr_req.en),
        .data_i (wr_req.data),
        .bl_o   (bl),
        .blb_o  (blb)
    );

    rf_cell_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
        .clk          (clk),
        .rst          (rst),
        .wl_i         (wl),
        .bl_i         (bl),
        .blb_i        (blb),
        .rd_capture_i (rd_capture),
        .ra_a_i       (rd_a_addr),
        .ra_b_i       (rd_b_addr),
        .rd_a_o       (rd_a_data),
        .rd_b_o       (rd_b_data)
    );

    assign phase_o = (phase == PH_WRITE);

    // R3 / R10: captured read data holds across the write-half edge
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        phase_o |=> ($stable(rd_a_data) && $stable(rd_b_data)));

    // R9: no write line rises during the read half
    p_write_half_only_r9: assert property (@(posedge clk) disable iff (rst)
        (|wl) |-> phase_o);

endmodule

// File: tb/rf_phase_dual_read_tb_top.sv
`timescale 1ns/1ps
module rf_phase_dual_read_tb_top;

    localparam int unsigned AW = 5;
    localparam int unsigned W  = 32;
    localparam int unsigned NV = 10;

    typedef struct packed {
        logic [AW-1:0] ra;
        logic [AW-1:0] rb;
        logic          we;
        logic [AW-1:0] wa;
        logic [W-1:0]  wd;
        logic [W-1:0]  ea;
        logic [W-1:0]  eb;
    } vec_t;

    // Each row: read A, read B, write enable/address/data, expected A, expected B
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  1'b1, 5'd1,  32'h1111_1111, 32'h0000_0000, 32'h0000_0000},
        '{5'd1,  5'd1,  1'b1, 5'd2,  32'h2222_2222, 32'h1111_1111, 32'h1111_1111},
        '{5'd2,  5'd1,  1'b1, 5'd2,  32'hA5A5_0F0F, 32'h2222_2222, 32'h1111_1111},
        '{5'd2,  5'd0,  1'b1, 5'd0,  32'hFFFF_FFFF, 32'hA5A5_0F0F, 32'h0000_0000},
        '{5'd0,  5'd31, 1'b1, 5'd31, 32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0000},
        '{5'd31, 5'd2,  1'b0, 5'd2,  32'h0000_0000, 32'hDEAD_BEEF, 32'hA5A5_0F0F},
        '{5'd2,  5'd31, 1'b0, 5'd31, 32'h1234_5678, 32'hA5A5_0F0F, 32'hDEAD_BEEF},
        '{5'd31, 5'd1,  1'b1, 5'd1,  32'h0000_0000, 32'hDEAD_BEEF, 32'h1111_1111},
        '{5'd1,  5'd30, 1'b1, 5'd30, 32'h8000_0001, 32'h0000_0000, 32'h0000_0000},
        '{5'd30, 5'd30, 1'b0, 5'd0,  32'h0000_0000, 32'h8000_0001, 32'h8000_0001}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          phase_o;
    logic [AW-1:0] rd_a_addr;
    logic [AW-1:0] rd_b_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_data;
    logic [W-1:0]  rd_a_data;
    logic [W-1:0]  rd_b_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rf_phase_dual_read dut_i (
        .clk       (clk),
        .rst       (rst),
        .phase_o   (phase_o),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One register-file cycle, entered and left at a falling edge in the read half
    task automatic rf_cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                            input logic we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                            output logic [W-1:0] got_a, output logic [W-1:0] got_b);
        rd_a_addr = ra;
        rd_b_addr = rb;
        wr_en     = we;
        wr_addr   = wa;
        wr_data   = wd;
        @(posedge clk);
        @(negedge clk);
        got_a = rd_a_data;
        got_b = rd_b_data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ga;
        logic [W-1:0] gb;
        rst = 1'b1; rd_a_addr = '0; rd_b_addr = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 phase after reset", W'(phase_o), W'(0));
        check("R1 port A after reset", rd_a_data, '0);
        check("R1 port B after reset", rd_b_data, '0);

        // R2: phase alternates each clock
        @(negedge clk);
        check("R2 write half", W'(phase_o), W'(1));
        @(negedge clk);
        check("R2 read half", W'(phase_o), W'(0));

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            rf_cycle(VECS[i].ra, VECS[i].rb, VECS[i].we, VECS[i].wa, VECS[i].wd, ga, gb);
            check($sformatf("R3 R5 R6 R7 R8 table row %0d port A", i), ga, VECS[i].ea);
            check($sformatf("R4 R5 R6 R7 R8 table row %0d port B", i), gb, VECS[i].eb);
        end

        // R10: read addresses changed during the write half are ignored
        rd_a_addr = 5'd31; rd_b_addr = 5'd30; wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rd_a_addr = 5'd1; rd_b_addr = 5'd2;
        @(posedge clk);
        @(negedge clk);
        check("R10 port A held", rd_a_data, 32'hDEAD_BEEF);
        check("R10 port B held", rd_b_data, 32'h8000_0001);

        // R9: write request raised only in the read half is ignored
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hCAFE_F00D;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rf_cycle(5'd5, 5'd5, 1'b0, 5'd0, '0, ga, gb);
        check("R9 port A reg5 untouched", ga, '0);
        check("R9 port B reg5 untouched", gb, '0);

        // R1: reset clears stored registers
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 phase after second reset", W'(phase_o), W'(0));
        rf_cycle(5'd31, 5'd30, 1'b0, 5'd0, '0, ga, gb);
        check("R1 reg31 cleared", ga, '0);
        check("R1 reg30 cleared", gb, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule